// File: doc/BRIEF.md
# Segment Selector Translation Unit

This block turns a logical address, made of a 16-bit selector and a 32-bit offset, into a 32-bit linear address. It splits the selector into a descriptor index and a table choice, reads the 64-bit segment descriptor from memory as two 32-bit words, checks it, and adds the segment base to the offset. Each request ends in exactly one response, which carries either a linear address or a fault code.

Two descriptor tables are used. The global table is located directly by a base and a 16-bit byte limit. The local table is located only through a selector held in a local-table register. That selector indexes the global table, and the descriptor found there gives the local table's base and limit. A local access therefore makes two chained descriptor fetches.

Top module: `seg_xlate_top`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0 and `mem_rd_en` is 0.
- R2: Selector bits 15:3 are the index and bit 2 picks the table (0 global, 1 local). Bits 1:0 have no effect. A descriptor is read at table base + index*8, as a low word at +0 followed on the next cycle by a high word at +4. The memory returns read data on the cycle after `mem_rd_en`.
- R3: A global selector with index 0 faults with cause 1. No memory read is made, and the response comes on the cycle after acceptance.
- R4: If index*8+7 is greater than the table's byte limit, the access faults with cause 2 and the segment descriptor is not read.
- R5: The segment base is high[31:24], high[7:0] and low[31:16], from most to least significant. The linear address is base + offset, modulo 2^32.
- R6: The 20-bit limit is high[19:16] above low[15:0]. When high[23] is 1, the byte limit is limit*4096+4095; otherwise it is the limit itself. An offset greater than the byte limit faults with cause 4.
- R7: A descriptor with high[15] = 0 is not present and faults with cause 3.
- R8: A local selector first fetches the global descriptor named by the local-table selector, and then fetches the segment descriptor at local base + index*8. In the local table, index 0 is a valid entry.
- R9: A local-table selector that has table bit 1, or index 0, faults with cause 5 and no read is made. If the local-table selector lies outside the global limit, the access faults with cause 2. If the local-table descriptor is not present, it faults with cause 3. If the index lies outside the local table's limit, it faults with cause 2.
- R10: A response holds `rsp_valid` for one cycle. `rsp_fault` is 1 exactly when `rsp_cause` is not 0, and a faulting response carries `rsp_lin` = 0.
- R11: `req_ready` is high in every cycle that has a response, so a new request can be accepted in the same cycle as a response. No memory read is issued while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit can accept a request |
| req_sel | input | 16 | Selector of the logical address |
| req_off | input | 32 | Offset of the logical address |
| gdt_base | input | 32 | Linear base of the global table |
| gdt_limit | input | 16 | Byte limit of the global table |
| ldt_sel | input | 16 | Selector that names the local table |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Memory read address |
| mem_rd_data | input | 32 | Read data, one cycle after the strobe |
| rsp_valid | output | 1 | Response present, one cycle |
| rsp_fault | output | 1 | Response is a fault |
| rsp_cause | output | 3 | Fault code, 0 when there is no fault |
| rsp_lin | output | 32 | Linear address, 0 on a fault |

## Verification
A response and the acceptance of the next request can fall in the same cycle. This is because `req_ready` stays high while `rsp_valid` is asserted. The bench provokes this by holding `req_valid` high across a local-table translation, with a null selector queued behind it. It then checks that `rsp_valid` and `req_ready` are both high in the response cycle, and that the null fault follows on the very next cycle. The scoreboard checks that each of the two responses still matches its own request in order.

// File: rtl/seg_xlate_pkg.sv
// Package: shared constants, fault codes and FSM state type for the
// selector translation unit. Assumes 16-bit selectors and 32-bit addresses.
package seg_xlate_pkg;
    localparam int ADDR_W     = 32;
    localparam int SEL_W      = 16;
    localparam int IDX_W      = 13;
    localparam int TLIM_W     = 16;
    localparam int DESC_SHIFT = 3;
    localparam int GRAN_SHIFT = 12;
    localparam int LIM_W      = 20;

    typedef enum logic [2:0] {
        CAUSE_NONE    = 3'd0,
        CAUSE_NULL    = 3'd1,
        CAUSE_TBL_LIM = 3'd2,
        CAUSE_ABSENT  = 3'd3,
        CAUSE_SEG_LIM = 3'd4,
        CAUSE_LDT_SEL = 3'd5
    } fault_cause_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RD_LO  = 3'd1,
        ST_RD_HI  = 3'd2,
        ST_RD_END = 3'd3,
        ST_DONE   = 3'd4
    } walk_st_e;
endpackage

// File: rtl/seg_sel_split.sv
// Selector splitter: separates index and table bit, flags the null
// selector and forms the first and last byte offsets of the descriptor.
// Assumes the requested-privilege bits are dropped by the caller.
module seg_sel_split
    import seg_xlate_pkg::*;
(
    input  logic [SEL_W-1:2]  sel_hi,
    output logic [IDX_W-1:0]  idx,
    output logic              ti,
    output logic              is_null,
    output logic [TLIM_W-1:0] first_off,
    output logic [TLIM_W-1:0] last_off
);
    // Purpose: pure field decode of the selector.
    always_comb begin
        idx       = sel_hi[SEL_W-1:3];
        ti        = sel_hi[2];
        is_null   = (sel_hi[2] == 1'b0) && (sel_hi[SEL_W-1:3] == '0);
        first_off = {sel_hi[SEL_W-1:3], {DESC_SHIFT{1'b0}}};
        last_off  = {sel_hi[SEL_W-1:3], {DESC_SHIFT{1'b1}}};
    end
endmodule

// File: rtl/seg_desc_unpack.sv
// Descriptor unpacker: assembles base, byte limit and present flag from
// the two 32-bit descriptor words. GRAN_EN selects whether the
// granularity bit scales the limit by 4 KB.
module seg_desc_unpack
    import seg_xlate_pkg::*;
#(
    parameter bit GRAN_EN = 1'b1
) (
    input  logic [31:0]       lo_word,
    input  logic [31:0]       hi_word,
    output logic [ADDR_W-1:0] base,
    output logic [ADDR_W-1:0] byte_lim,
    output logic              present
);
    logic [LIM_W-1:0] raw_lim;

    // Purpose: gather split base and limit fields.
    always_comb begin
        base    = {hi_word[31:24], hi_word[7:0], lo_word[31:16]};
        raw_lim = {hi_word[19:16], lo_word[15:0]};
        present = hi_word[15];
    end

    generate
        if (GRAN_EN) begin : g_gran
            // Purpose: scale the limit to 4 KB units when the granularity bit is set.
            always_comb begin
                if (hi_word[23])
                    byte_lim = {raw_lim, {GRAN_SHIFT{1'b1}}};
                else
                    byte_lim = {{(ADDR_W-LIM_W){1'b0}}, raw_lim};
            end
        end else begin : g_byte
            logic unused_g;
            // Purpose: byte-granular limit only.
            always_comb begin
                unused_g = hi_word[23];
                byte_lim = {{(ADDR_W-LIM_W){1'b0}}, raw_lim};
            end
        end
    endgenerate
endmodule

// File: rtl/seg_range_chk.sv
// Range check: flags a value strictly greater than an inclusive limit.
module seg_range_chk
    import seg_xlate_pkg::*;
(
    input  logic [ADDR_W-1:0] value,
    input  logic [ADDR_W-1:0] limit,
    output logic              over
);
    // Purpose: unsigned bound comparison.
    always_comb over = (value > limit);
endmodule

// File: rtl/seg_xlate_top.sv
// Selector translation unit top. Accepts a selector/offset request and
// walks one or two descriptor fetches: a local table is reached through
// the global table. It checks the table limits, the present bit and the
// segment limit, then returns base+offset or a fault code. Assumes a
// memory that returns read data one cycle after the strobe, and accepts
// a new request in the response cycle.
module seg_xlate_top
    import seg_xlate_pkg::*;
#(
    parameter bit GRAN_EN = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [15:0]       req_sel,
    input  logic [31:0]       req_off,
    input  logic [31:0]       gdt_base,
    input  logic [15:0]       gdt_limit,
    input  logic [15:0]       ldt_sel,
    output logic              mem_rd_en,
    output logic [31:0]       mem_rd_addr,
    input  logic [31:0]       mem_rd_data,
    output logic              rsp_valid,
    output logic              rsp_fault,
    output logic [2:0]        rsp_cause,
    output logic [31:0]       rsp_lin
);
    localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

    walk_st_e           st_q, nxt_st;
    logic [ADDR_W-1:0]  desc_addr_q, nxt_addr;
    logic               ldt_phase_q, nxt_ldt;
    logic [IDX_W-1:0]   idx_q, nxt_idx;
    logic [ADDR_W-1:0]  off_q, nxt_off;
    logic [31:0]        lo_q, nxt_lo;
    logic               fault_q, nxt_fault;
    fault_cause_e       cause_q, nxt_cause;
    logic [ADDR_W-1:0]  lin_q, nxt_lin;

    logic [IDX_W-1:0]   rq_idx, lt_idx, cu_idx;
    logic               rq_ti, lt_ti, cu_ti;
    logic               rq_null, lt_null, cu_null;
    logic [TLIM_W-1:0]  rq_first, rq_last, lt_first, lt_last, cu_first, cu_last;
    logic               unused_sel;

    logic [ADDR_W-1:0]  d_base, d_lim;
    logic               d_present;
    logic               tbl_over, seg_over;

    // Purpose: requested-privilege bits take no part in translation.
    always_comb unused_sel = ^{req_sel[1:0], ldt_sel[1:0], cu_ti, cu_null, cu_idx, lt_last[0]};

    seg_sel_split u_req_split (
        .sel_hi(req_sel[15:2]), .idx(rq_idx), .ti(rq_ti), .is_null(rq_null),
        .first_off(rq_first), .last_off(rq_last)
    );
    seg_sel_split u_ldt_split (
        .sel_hi(ldt_sel[15:2]), .idx(lt_idx), .ti(lt_ti), .is_null(lt_null),
        .first_off(lt_first), .last_off(lt_last)
    );
    seg_sel_split u_cur_split (
        .sel_hi({idx_q, 1'b1}), .idx(cu_idx), .ti(cu_ti), .is_null(cu_null),
        .first_off(cu_first), .last_off(cu_last)
    );

    seg_desc_unpack #(.GRAN_EN(GRAN_EN)) u_unpack (
        .lo_word(lo_q), .hi_word(mem_rd_data),
        .base(d_base), .byte_lim(d_lim), .present(d_present)
    );

    seg_range_chk u_tbl_chk (
        .value({{(ADDR_W-TLIM_W){1'b0}}, cu_last}), .limit(d_lim), .over(tbl_over)
    );
    seg_range_chk u_seg_chk (
        .value(off_q), .limit(d_lim), .over(seg_over)
    );

    // Purpose: handshake and memory port driven from the walk state.
    always_comb begin
        req_ready   = (st_q == ST_IDLE) || (st_q == ST_DONE);
        mem_rd_en   = (st_q == ST_RD_LO) || (st_q == ST_RD_HI);
        mem_rd_addr = (st_q == ST_RD_HI) ? desc_addr_q + WORD_STEP : desc_addr_q;
        rsp_valid   = (st_q == ST_DONE);
        rsp_fault   = fault_q;
        rsp_cause   = cause_q;
        rsp_lin     = lin_q;
    end

    // Purpose: next-state and result computation of the descriptor walk.
    always_comb begin
        nxt_st    = st_q;
        nxt_addr  = desc_addr_q;
        nxt_ldt   = ldt_phase_q;
        nxt_idx   = idx_q;
        nxt_off   = off_q;
        nxt_lo    = lo_q;
        nxt_fault = fault_q;
        nxt_cause = cause_q;
        nxt_lin   = lin_q;
        unique case (st_q)
            ST_IDLE, ST_DONE: begin
                nxt_st = ST_IDLE;
                if (req_valid) begin
                    nxt_idx = rq_idx;
                    nxt_off = req_off;
                    if (!rq_ti) begin
                        if (rq_null) begin
                            nxt_st = ST_DONE; nxt_fault = 1'b1;
                            nxt_cause = CAUSE_NULL; nxt_lin = '0;
                        end else if (rq_last > gdt_limit) begin
                            nxt_st = ST_DONE; nxt_fault = 1'b1;
                            nxt_cause = CAUSE_TBL_LIM; nxt_lin = '0;
                        end else begin
                            nxt_addr = gdt_base + {{(ADDR_W-TLIM_W){1'b0}}, rq_first};
                            nxt_ldt  = 1'b0;
                            nxt_st   = ST_RD_LO;
                        end
                    end else begin
                        if (lt_ti || (lt_idx == '0)) begin
                            nxt_st = ST_DONE; nxt_fault = 1'b1;
                            nxt_cause = CAUSE_LDT_SEL; nxt_lin = '0;
                        end else if ({lt_first[TLIM_W-1:DESC_SHIFT], {DESC_SHIFT{1'b1}}} > gdt_limit) begin
                            nxt_st = ST_DONE; nxt_fault = 1'b1;
                            nxt_cause = CAUSE_TBL_LIM; nxt_lin = '0;
                        end else begin
                            nxt_addr = gdt_base + {{(ADDR_W-TLIM_W){1'b0}}, lt_first};
                            nxt_ldt  = 1'b1;
                            nxt_st   = ST_RD_LO;
                        end
                    end
                end
            end
            ST_RD_LO: nxt_st = ST_RD_HI;
            ST_RD_HI: begin
                nxt_lo = mem_rd_data;
                nxt_st = ST_RD_END;
            end
            ST_RD_END: begin
                if (!d_present) begin
                    nxt_st = ST_DONE; nxt_fault = 1'b1;
                    nxt_cause = CAUSE_ABSENT; nxt_lin = '0;
                end else if (ldt_phase_q) begin
                    if (tbl_over) begin
                        nxt_st = ST_DONE; nxt_fault = 1'b1;
                        nxt_cause = CAUSE_TBL_LIM; nxt_lin = '0;
                    end else begin
                        nxt_addr = d_base + {{(ADDR_W-TLIM_W){1'b0}}, cu_first};
                        nxt_ldt  = 1'b0;
                        nxt_st   = ST_RD_LO;
                    end
                end else if (seg_over) begin
                    nxt_st = ST_DONE; nxt_fault = 1'b1;
                    nxt_cause = CAUSE_SEG_LIM; nxt_lin = '0;
                end else begin
                    nxt_st = ST_DONE; nxt_fault = 1'b0;
                    nxt_cause = CAUSE_NONE; nxt_lin = d_base + off_q;
                end
            end
            default: nxt_st = ST_IDLE;
        endcase
    end

    // Purpose: state registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= ST_IDLE;
            desc_addr_q <= '0;
            ldt_phase_q <= 1'b0;
            idx_q       <= '0;
            off_q       <= '0;
            lo_q        <= '0;
            fault_q     <= 1'b0;
            cause_q     <= CAUSE_NONE;
            lin_q       <= '0;
        end else begin
            st_q        <= nxt_st;
            desc_addr_q <= nxt_addr;
            ldt_phase_q <= nxt_ldt;
            idx_q       <= nxt_idx;
            off_q       <= nxt_off;
            lo_q        <= nxt_lo;
            fault_q     <= nxt_fault;
            cause_q     <= nxt_cause;
            lin_q       <= nxt_lin;
        end
    end
endmodule

// File: rtl/seg_xlate_chk.sv
// Checker for the selector translation unit, bound to every instance of
// the top. Observes ports only.
module seg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_ready,
    input logic [15:0] req_sel,
    input logic        mem_rd_en,
    input logic [31:0] mem_rd_addr,
    input logic        rsp_valid,
    input logic        rsp_fault,
    input logic [2:0]  rsp_cause,
    input logic [31:0] rsp_lin
);
    assert_null_fault_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_sel[2] && (req_sel[15:3] == 13'd0))
        |=> (rsp_valid && rsp_fault && (rsp_cause == 3'd1)));

    assert_word_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd_en) |=> (mem_rd_en && (mem_rd_addr == $past(mem_rd_addr) + 32'd4)));

    assert_fault_zero_lin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_lin == 32'd0));

    assert_fault_code_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_fault == (rsp_cause != 3'd0)));

    assert_ready_on_rsp_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> req_ready);

    assert_no_read_when_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !mem_rd_en);
endmodule

bind seg_xlate_top seg_xlate_chk u_seg_xlate_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_sel(req_sel), .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr),
    .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_lin(rsp_lin)
);

// File: tb/seg_xlate_top_bench.sv
// Scoreboard bench: the driver queues expected responses, a monitor
// compares them as responses appear; a memory model serves descriptors.
module seg_xlate_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [15:0] req_sel = '0;
    logic [31:0] req_off = '0;
    logic [31:0] gdt_base = 32'h1000;
    logic [15:0] gdt_limit = 16'h007F;
    logic [15:0] ldt_sel = 16'h0020;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic [31:0] mem_rd_data = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [2:0]  rsp_cause;
    logic [31:0] rsp_lin;

    typedef struct {
        logic        fault;
        logic [2:0]  cause;
        logic [31:0] lin;
        string       tag;
    } exp_t;

    exp_t        exp_q[$];
    logic [31:0] rd_log[$];
    logic [31:0] mem [logic [31:0]];
    int          n_chk = 0;
    int          n_fail = 0;
    int          cyc = 0;
    bit          ended = 1'b0;

    always #4 clk = ~clk;

    seg_xlate_top u_seg_xlate_top (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_sel(req_sel), .req_off(req_off), .gdt_base(gdt_base),
        .gdt_limit(gdt_limit), .ldt_sel(ldt_sel), .mem_rd_en(mem_rd_en),
        .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
        .rsp_lin(rsp_lin)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic put_desc(input logic [31:0] a, input logic [31:0] base,
                            input logic [19:0] lim, input bit g, input bit p);
        mem[a]     = {base[15:0], lim[15:0]};
        mem[a + 4] = {base[31:24], g, 3'b000, lim[19:16], p, 7'b0010010, base[23:16]};
    endtask

    // Memory model: one-cycle read latency, logs every read address.
    always @(posedge clk) begin
        if (mem_rd_en) begin
            mem_rd_data <= mem.exists(mem_rd_addr) ? mem[mem_rd_addr] : 32'h0;
            rd_log.push_back(mem_rd_addr);
        end
    end

    // Monitor: compare each response with the head of the scoreboard (R10, R11).
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            chk(req_ready == 1'b1, "R11 ready in response cycle", {31'd0, req_ready}, 32'd1);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R10 unexpected response", {29'd0, rsp_cause}, 32'd0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                chk(rsp_fault == e.fault, {e.tag, " fault flag"}, {31'd0, rsp_fault}, {31'd0, e.fault});
                chk(rsp_cause == e.cause, {e.tag, " cause"}, {29'd0, rsp_cause}, {29'd0, e.cause});
                chk(rsp_lin == e.lin, {e.tag, " linear (R10 when faulting)"}, rsp_lin, e.lin);
            end
        end
    end

    task automatic send(input logic [15:0] sel, input logic [31:0] off,
                        input bit f, input logic [2:0] c, input logic [31:0] lin, input string tag);
        exp_t e;
        e.fault = f; e.cause = c; e.lin = lin; e.tag = tag;
        exp_q.push_back(e);
        rd_log.delete();
        req_sel = sel; req_off = off; req_valid = 1'b1;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic chk_reads(input int n, input logic [31:0] a0, input logic [31:0] a2, input string req);
        chk(rd_log.size() == n, {req, " read count"}, rd_log.size(), n);
        if (n > 0 && rd_log.size() == n) begin
            chk(rd_log[0] == a0 && rd_log[1] == a0 + 4, {req, " first pair"}, rd_log[0], a0);
            if (n > 2) chk(rd_log[2] == a2 && rd_log[3] == a2 + 4, {req, " second pair"}, rd_log[2], a2);
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000 && !ended) begin
            ended = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        put_desc(32'h1008, 32'h0010_0000, 20'h0FFFF, 1'b0, 1'b1);
        put_desc(32'h1010, 32'h1234_5678, 20'h00003, 1'b1, 1'b1);
        put_desc(32'h1018, 32'h0000_0000, 20'hFFFFF, 1'b0, 1'b0);
        put_desc(32'h1020, 32'h0000_2000, 20'h0001F, 1'b0, 1'b1);
        put_desc(32'h1028, 32'h0000_4000, 20'h0001F, 1'b0, 1'b0);
        put_desc(32'h1030, 32'h0000_3000, 20'h0000F, 1'b0, 1'b1);
        put_desc(32'h2000, 32'hA000_0000, 20'h000FF, 1'b0, 1'b1);
        put_desc(32'h2010, 32'h0000_0100, 20'hFFFFF, 1'b1, 1'b1);
        put_desc(32'h2018, 32'h0000_0000, 20'h000FF, 1'b0, 1'b0);
        put_desc(32'h3008, 32'h0000_5000, 20'h00010, 1'b0, 1'b1);

        repeat (3) @(negedge clk);
        chk(req_ready == 1'b1, "R1 ready in reset", {31'd0, req_ready}, 32'd1);
        chk(rsp_valid == 1'b0 && mem_rd_en == 1'b0, "R1 idle outputs", {30'd0, rsp_valid, mem_rd_en}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        send(16'h0000, 32'h0, 1'b1, 3'd1, 32'h0, "R3 null selector");
        chk_reads(0, 0, 0, "R3 null no read");
        send(16'h0003, 32'h55, 1'b1, 3'd1, 32'h0, "R3 null with privilege bits");
        send(16'h0008, 32'h1234, 1'b0, 3'd0, 32'h0010_1234, "R5 global translate");
        chk_reads(2, 32'h1008, 0, "R2 global fetch");
        send(16'h000B, 32'h1234, 1'b0, 3'd0, 32'h0010_1234, "R2 privilege bits ignored");
        send(16'h0008, 32'hFFFF, 1'b0, 3'd0, 32'h0010_FFFF, "R6 at byte limit");
        send(16'h0008, 32'h1_0000, 1'b1, 3'd4, 32'h0, "R6 past byte limit");
        send(16'h0010, 32'h3FFF, 1'b0, 3'd0, 32'h1234_9677, "R6 granular at limit");
        send(16'h0010, 32'h4000, 1'b1, 3'd4, 32'h0, "R6 granular past limit");
        send(16'h0018, 32'h0, 1'b1, 3'd3, 32'h0, "R7 absent segment");
        send(16'h0080, 32'h0, 1'b1, 3'd2, 32'h0, "R4 index past global limit");
        chk_reads(0, 0, 0, "R4 no read");
        send(16'h0078, 32'h0, 1'b1, 3'd3, 32'h0, "R4 last index inside limit");

        send(16'h0004, 32'h10, 1'b0, 3'd0, 32'hA000_0010, "R8 local index 0");
        chk_reads(4, 32'h1020, 32'h2000, "R8 chained fetch");
        send(16'h0014, 32'h8000_0000, 1'b0, 3'd0, 32'h8000_0100, "R8 local granular");
        send(16'h001C, 32'h0, 1'b1, 3'd3, 32'h0, "R7 absent local segment");
        send(16'h0024, 32'h0, 1'b1, 3'd2, 32'h0, "R9 index past local limit");
        chk_reads(2, 32'h1020, 0, "R9 local table only");

        ldt_sel = 16'h0000;
        send(16'h0004, 32'h0, 1'b1, 3'd5, 32'h0, "R9 null local-table selector");
        chk_reads(0, 0, 0, "R9 no read");
        ldt_sel = 16'h0024;
        send(16'h0004, 32'h0, 1'b1, 3'd5, 32'h0, "R9 local-table selector in local table");
        ldt_sel = 16'h0028;
        send(16'h0004, 32'h0, 1'b1, 3'd3, 32'h0, "R9 absent local-table descriptor");
        ldt_sel = 16'h0088;
        send(16'h0004, 32'h0, 1'b1, 3'd2, 32'h0, "R9 local-table selector past global limit");

        // Back-to-back: response and next acceptance in one cycle (R11).
        ldt_sel = 16'h0030;
        begin
            exp_t e1, e2;
            e1.fault = 1'b0; e1.cause = 3'd0; e1.lin = 32'h5010; e1.tag = "R11 first of pair";
            e2.fault = 1'b1; e2.cause = 3'd1; e2.lin = 32'h0;    e2.tag = "R11 second of pair";
            exp_q.push_back(e1);
            exp_q.push_back(e2);
            req_sel = 16'h000C; req_off = 32'h10; req_valid = 1'b1;
            while (!req_ready) @(negedge clk);
            @(negedge clk);
            req_sel = 16'h0000; req_off = 32'h0;
            while (!req_ready) @(negedge clk);
            chk(rsp_valid == 1'b1, "R11 response while next request accepted", {31'd0, rsp_valid}, 32'd1);
            @(negedge clk);
            req_valid = 1'b0;
            chk(rsp_valid == 1'b1, "R11 second response next cycle", {31'd0, rsp_valid}, 32'd1);
            @(negedge clk);
            chk(rsp_valid == 1'b0 && exp_q.size() == 0, "R10 one-cycle response", {31'd0, rsp_valid}, 32'd0);
        end

        repeat (3) @(negedge clk);
        if (!ended) begin
            ended = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule